// File: doc/BRIEF.md
# Halfword and Signed Load/Store Unit

This unit carries out a single halfword or signed-byte memory transfer described by a 32-bit instruction word. A pulse on `start` hands it the instruction, the four condition flags, the base and offset register values and the low half of the source register. All of these are looked up by an outside register file using the index outputs that the unit decodes from the same instruction word. In the cycle it accepts the instruction, the unit evaluates the condition code, checks the encoding, and works out both the access address and the updated base.

When the instruction is to execute, the unit places one request on a simple memory port and holds it until `mem_ready`. The memory port is little-endian, word-wide and uses byte enables. One cycle after the handshake, the unit pulses `done`. For loads, `done` comes with the zero- or sign-extended result and the destination index. It also comes with any base write-back. An instruction whose condition fails, or whose encoding the unit does not handle (including the swap pattern), makes no access. Such an instruction ends with `done` and a `skipped` or `unsupported` flag one cycle after it is accepted.

Top module: `hsx_ldst_unit`

## Requirements
- R1: Flags arrive as `nzcv[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V. The condition code in instruction bits [31:28] passes as follows: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never. A failing code ends with `done` and `skipped`, with no memory request and no register write.
- R2: An instruction whose condition passes is handled only when all of these hold: bits [27:25]=000, bit 22=0, bits [11:8]=0000, bit 7=1, bit 4=1, and bits [6:5]!=00. A store (bit 20=0) is handled only with bits [6:5]=01. Any other passing instruction ends with `done` and `unsupported`, with no request and no write.
- R3: Bit 23 set adds the offset to the base and clear subtracts it. Bit 24 set makes base±offset the access address. Bit 24 clear makes the unmodified base the access address.
- R4: Base write-back (`wb_we` with `done`) happens when bit 21 is set or bit 24 is clear. It carries `wb_idx` = bits [19:16] and `wb_data` = base±offset.
- R5: A load (bit 20=1) raises `rd_we` with `done` and `rd_idx` = bits [15:12]. For bits [6:5], 01 zero-extends a halfword, 10 sign-extends a byte from its bit 7, and 11 sign-extends a halfword from its bit 15. A store never raises `rd_we`.
- R6: A byte is taken from lane `addr[1:0]` (lane k is `mem_rdata[8k+7:8k]`) with `mem_be` = 1<<addr[1:0]. A halfword is taken from the low half when addr[1]=0 and the high half when addr[1]=1, and addr[0] is ignored.
- R7: A store drives `mem_we`=1 and `mem_wdata` = {store_half, store_half}. Its `mem_be` is 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1. A load drives `mem_we`=0 with the same halfword enables.
- R8: The request stays asserted with a stable address and stable enables until `mem_ready`. `done` is a one-cycle pulse one cycle after the accepting edge, and it never overlaps a request.
- R9: An instruction that makes no access raises `done` in the first cycle after the edge that accepted `start`.
- R10: After reset, `busy`, `mem_req`, `done`, `rd_we` and `wb_we` are all low.
- R11: `rf_base_idx`, `rf_offs_idx` and `rf_src_idx` show instruction bits [19:16], [3:0] and [15:12] in the same cycle, for register lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept the instruction on the inputs (honoured only when idle) |
| instr | input | 32 | Instruction word |
| nzcv | input | 4 | Condition flags N, Z, C, V |
| base_val | input | ADDR_W | Base register value |
| offs_val | input | ADDR_W | Offset register value |
| store_half | input | 16 | Low half of the source register |
| rf_base_idx | output | 4 | Base register index for lookup |
| rf_offs_idx | output | 4 | Offset register index for lookup |
| rf_src_idx | output | 4 | Source register index for lookup |
| busy | output | 1 | Instruction in flight |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | DATA_W/8 | Byte enables |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| done | output | 1 | Instruction finished |
| skipped | output | 1 | With done: condition failed |
| unsupported | output | 1 | With done: encoding not handled |
| rd_we | output | 1 | Destination write strobe |
| rd_idx | output | 4 | Destination index |
| rd_data | output | DATA_W | Extended load value |
| wb_we | output | 1 | Base write-back strobe |
| wb_idx | output | 4 | Base index |
| wb_data | output | ADDR_W | Updated base |

## Verification
Two situations are the hardest to reach. One is an instruction whose condition fails while its encoding is also invalid: it must report `skipped` rather than `unsupported`. The other is a signed store, which looks legal except for one bit. Random instruction words are therefore built field by field. The mandatory bits are usually forced to their legal values, so the condition, kind, direction and indexing fields vary independently. A minority of words keep random noise in those bits to exercise the rejection paths. Memory latency varies from zero to three wait cycles so that the request-hold behaviour is observed, and directed cases cover every byte lane, both halfword positions and sign bits set in the loaded data.

// File: rtl/hsx_pkg.sv
// Shared types for the halfword/signed load/store unit.
// Assumes the 32-bit instruction layout used by the decoder.
package hsx_pkg;

    localparam int REG_IDX_W = 4;

    // Transfer kind from instruction bits [6:5]
    typedef enum logic [1:0] {
        XK_SWAP  = 2'b00,
        XK_UHALF = 2'b01,
        XK_SBYTE = 2'b10,
        XK_SHALF = 2'b11
    } xfer_kind_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    // Fields pulled out of one instruction word
    typedef struct packed {
        logic [3:0]           cond;
        logic                 pre;
        logic                 up;
        logic                 wback;
        logic                 load;
        logic [REG_IDX_W-1:0] base_idx;
        logic [REG_IDX_W-1:0] data_idx;
        logic [REG_IDX_W-1:0] offs_idx;
        xfer_kind_e           kind;
        logic                 form_ok;
    } op_fields_t;

endpackage

// File: rtl/hsx_cond_eval.sv
// Condition evaluator: maps a 4-bit condition code and the N, Z, C, V flags
// to a pass/fail decision. Purely combinational.
// Assumes flags are packed as {N, Z, C, V}.
module hsx_cond_eval (
    input  logic [3:0] cond,
    input  logic [3:0] nzcv,
    output logic       pass
);
    logic fn, fz, fc, fv;

    assign fn = nzcv[3];
    assign fz = nzcv[2];
    assign fc = nzcv[1];
    assign fv = nzcv[0];

    // Select the flag test for the given code
    always_comb begin
        unique case (cond)
            4'h0:    pass = fz;
            4'h1:    pass = !fz;
            4'h2:    pass = fc;
            4'h3:    pass = !fc;
            4'h4:    pass = fn;
            4'h5:    pass = !fn;
            4'h6:    pass = fv;
            4'h7:    pass = !fv;
            4'h8:    pass = fc && !fz;
            4'h9:    pass = !fc || fz;
            4'hA:    pass = (fn == fv);
            4'hB:    pass = (fn != fv);
            4'hC:    pass = !fz && (fn == fv);
            4'hD:    pass = fz || (fn != fv);
            4'hE:    pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/hsx_instr_dec.sv
// Instruction decoder: splits the word into fields and checks that it is a
// register-offset halfword/signed transfer the unit can carry out.
// Assumes stores are only legal as unsigned halfwords.
module hsx_instr_dec
    import hsx_pkg::*;
(
    input  logic [31:0] instr,
    output op_fields_t  fld
);
    logic fixed_ok;
    logic kind_ok;

    // Field extraction
    always_comb begin
        fld.cond     = instr[31:28];
        fld.pre      = instr[24];
        fld.up       = instr[23];
        fld.wback    = instr[21];
        fld.load     = instr[20];
        fld.base_idx = instr[19:16];
        fld.data_idx = instr[15:12];
        fld.offs_idx = instr[3:0];
        fld.kind     = xfer_kind_e'(instr[6:5]);
        fld.form_ok  = fixed_ok && kind_ok;
    end

    // Fixed-bit pattern of the register-offset form
    always_comb begin
        fixed_ok = (instr[27:25] == 3'b000) && !instr[22] &&
                   (instr[11:8] == 4'b0000) && instr[7] && instr[4];
    end

    // Kind legality: swap rejected, stores only as unsigned halfwords
    always_comb begin
        if (fld.kind == XK_SWAP)
            kind_ok = 1'b0;
        else if (!instr[20])
            kind_ok = (fld.kind == XK_UHALF);
        else
            kind_ok = 1'b1;
    end
endmodule

// File: rtl/hsx_addr_gen.sv
// Address generator: forms base plus or minus offset, and picks either that
// sum or the raw base as the access address (pre- or post-indexing).
module hsx_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offs,
    input  logic              up,
    input  logic              pre,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] new_base
);
    // Offset arithmetic and indexing choice
    always_comb begin
        new_base = up ? (base + offs) : (base - offs);
        acc_addr = pre ? new_base : base;
    end
endmodule

// File: rtl/hsx_lane_fmt.sv
// Lane formatter: builds byte enables and write data for a request, and
// extracts and extends the loaded value from a little-endian data word.
// Assumes DATA_W is a multiple of 16 bits.
module hsx_lane_fmt
    import hsx_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int HW_N   = DATA_W / 16,
    localparam int SEL_W  = $clog2(BE_W)
) (
    input  xfer_kind_e        kind,
    input  logic [SEL_W-1:0]  addr_lo,
    input  logic [15:0]       src_half,
    input  logic [DATA_W-1:0] rdata,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ld_val
);
    logic [7:0]  byte_lane [BE_W];
    logic [15:0] half_lane [HW_N];
    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    for (genvar g = 0; g < BE_W; g++) begin : g_byte
        assign byte_lane[g] = rdata[8*g +: 8];
    end

    for (genvar h = 0; h < HW_N; h++) begin : g_half
        assign half_lane[h] = rdata[16*h +: 16];
    end

    assign sel_byte = byte_lane[addr_lo];
    assign sel_half = half_lane[addr_lo[SEL_W-1:1]];
    assign wdata    = {HW_N{src_half}};

    // Byte enables from kind and low address bits
    always_comb begin
        if (kind == XK_SBYTE)
            be = BE_W'(1) << addr_lo;
        else
            be = BE_W'(2'b11) << {addr_lo[SEL_W-1:1], 1'b0};
    end

    // Zero or sign extension of the selected lane
    always_comb begin
        unique case (kind)
            XK_UHALF: ld_val = {{(DATA_W-16){1'b0}}, sel_half};
            XK_SBYTE: ld_val = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
            XK_SHALF: ld_val = {{(DATA_W-16){sel_half[15]}}, sel_half};
            default:  ld_val = '0;
        endcase
    end
endmodule

// File: rtl/hsx_ldst_unit.sv
// Halfword and signed load/store unit (top).
// Accepts one instruction per start pulse while idle, decides at issue whether
// it executes, makes at most one memory request, and reports the result with a
// one-cycle done pulse. Assumes operand values on the inputs correspond to the
// rf_* indices shown in the same cycle.
module hsx_ldst_unit
    import hsx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8,
    localparam int SEL_W = $clog2(BE_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [31:0]          instr,
    input  logic [3:0]           nzcv,
    input  logic [ADDR_W-1:0]    base_val,
    input  logic [ADDR_W-1:0]    offs_val,
    input  logic [15:0]          store_half,
    output logic [REG_IDX_W-1:0] rf_base_idx,
    output logic [REG_IDX_W-1:0] rf_offs_idx,
    output logic [REG_IDX_W-1:0] rf_src_idx,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BE_W-1:0]      mem_be,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ready,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 done,
    output logic                 skipped,
    output logic                 unsupported,
    output logic                 rd_we,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 wb_we,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [ADDR_W-1:0]    wb_data
);
    seq_state_e           state_q;
    op_fields_t           fld;
    logic                 cond_pass;
    logic [ADDR_W-1:0]    acc_addr;
    logic [ADDR_W-1:0]    new_base;
    logic                 issue;

    logic                 pass_q;
    logic                 form_q;
    logic                 load_q;
    logic                 wb_q;
    xfer_kind_e           kind_q;
    logic [REG_IDX_W-1:0] dst_q;
    logic [REG_IDX_W-1:0] bidx_q;
    logic [ADDR_W-1:0]    acc_q;
    logic [ADDR_W-1:0]    nb_q;
    logic [15:0]          half_q;
    logic [DATA_W-1:0]    rdata_q;
    logic                 exec_q;

    hsx_instr_dec u_dec (
        .instr (instr),
        .fld   (fld)
    );

    hsx_cond_eval u_cond (
        .cond (fld.cond),
        .nzcv (nzcv),
        .pass (cond_pass)
    );

    hsx_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .base     (base_val),
        .offs     (offs_val),
        .up       (fld.up),
        .pre      (fld.pre),
        .acc_addr (acc_addr),
        .new_base (new_base)
    );

    hsx_lane_fmt #(.DATA_W(DATA_W)) u_lane (
        .kind     (kind_q),
        .addr_lo  (acc_q[SEL_W-1:0]),
        .src_half (half_q),
        .rdata    (rdata_q),
        .be       (mem_be),
        .wdata    (mem_wdata),
        .ld_val   (rd_data)
    );

    assign rf_base_idx = fld.base_idx;
    assign rf_offs_idx = fld.offs_idx;
    assign rf_src_idx  = fld.data_idx;
    assign issue       = start && (state_q == ST_IDLE);

    // Sequencer: idle -> request (executing ops only) -> finish -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (issue) state_q <= (cond_pass && fld.form_ok) ? ST_REQ : ST_FIN;
                ST_REQ:  if (mem_ready) state_q <= ST_FIN;
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture decoded operation and computed addresses at issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            form_q <= 1'b0;
            load_q <= 1'b0;
            wb_q   <= 1'b0;
            kind_q <= XK_UHALF;
            dst_q  <= '0;
            bidx_q <= '0;
            acc_q  <= '0;
            nb_q   <= '0;
            half_q <= '0;
        end else if (issue) begin
            pass_q <= cond_pass;
            form_q <= fld.form_ok;
            load_q <= fld.load;
            wb_q   <= fld.wback || !fld.pre;
            kind_q <= fld.kind;
            dst_q  <= fld.data_idx;
            bidx_q <= fld.base_idx;
            acc_q  <= acc_addr;
            nb_q   <= new_base;
            half_q <= store_half;
        end
    end

    // Capture read data on the accepting handshake
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state_q == ST_REQ && mem_ready)
            rdata_q <= mem_rdata;
    end

    // Output decode from state and captured operation
    always_comb begin
        exec_q      = pass_q && form_q;
        busy        = (state_q != ST_IDLE);
        mem_req     = (state_q == ST_REQ);
        mem_we      = !load_q;
        mem_addr    = acc_q;
        done        = (state_q == ST_FIN);
        skipped     = done && !pass_q;
        unsupported = done && pass_q && !form_q;
        rd_we       = done && exec_q && load_q;
        rd_idx      = dst_q;
        wb_we       = done && exec_q && wb_q;
        wb_idx      = bidx_q;
        wb_data     = nb_q;
    end
endmodule

// File: rtl/hsx_ldst_chk.sv
// Checker for hsx_ldst_unit: protocol and outcome properties on its ports.
module hsx_ldst_chk #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BE_W-1:0]   mem_be,
    input logic              done,
    input logic              skipped,
    input logic              unsupported,
    input logic              rd_we,
    input logic              wb_we
);
    // Request held with stable address and enables until accepted
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));

    // done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // done never overlaps a request
    assert_done_noreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // skipped operation writes nothing
    assert_skip_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        skipped |-> (done && !rd_we && !wb_we && !unsupported));

    // unsupported operation writes nothing
    assert_unsup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (done && !rd_we && !wb_we));

    // stores always enable one halfword
    assert_store_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 2));

    // loads enable one byte or one halfword
    assert_load_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2));

    // register strobes only with done
    assert_write_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || wb_we) |-> done);

    // reset clears activity
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && !done));
endmodule

bind hsx_ldst_unit hsx_ldst_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (.*);

// File: tb/sim_hsx_ldst_unit.sv
`timescale 1ns/1ps
module sim_hsx_ldst_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  nzcv = '0;
    logic [31:0] base_val = '0;
    logic [31:0] offs_val = '0;
    logic [15:0] store_half = '0;
    logic [3:0]  rf_base_idx, rf_offs_idx, rf_src_idx;
    logic        busy, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, skipped, unsupported, rd_we, wb_we;
    logic [3:0]  rd_idx, wb_idx;
    logic [31:0] rd_data, wb_data;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    hsx_ldst_unit u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_cond(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy && !z;   9: return !cy || z;
            10: return n == v;    11: return n != v;
            12: return !z && n == v;
            13: return z || n != v;
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_form(input logic [31:0] w);
        if (w[27:25] != 0 || w[22] || w[11:8] != 0 || !w[7] || !w[4]) return 0;
        if (w[6:5] == 2'b00) return 0;
        if (!w[20] && w[6:5] != 2'b01) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] m_ext(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
        logic [7:0]  b = d[8*a[1:0] +: 8];
        logic [15:0] h = a[1] ? d[31:16] : d[15:0];
        case (k)
            2'b01: return {16'h0, h};
            2'b10: return {{24{b[7]}}, b};
            default: return {{16{h[15]}}, h};
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] c, input bit p, u, w, l,
                                       input logic [3:0] rn, rd, input logic [1:0] sh,
                                       input logic [3:0] rm);
        return {c, 3'b000, p, u, 1'b0, w, l, rn, rd, 4'b0000, 1'b1, sh, 1'b1, rm};
    endfunction

    task automatic run_op(input logic [31:0] w, input logic [3:0] f, input logic [31:0] b,
                          input logic [31:0] o, input logic [15:0] sh, input logic [31:0] rdat,
                          input int lat);
        bit pass = m_cond(w[31:28], f);
        bit form = m_form(w);
        bit ex = pass && form;
        logic [31:0] nb = w[23] ? b + o : b - o;
        logic [31:0] acc = w[24] ? nb : b;
        bit ld = w[20];
        logic [3:0] ebe = (w[6:5] == 2'b10) ? (4'b1 << acc[1:0]) : (acc[1] ? 4'hC : 4'h3);
        bit ewb = ex && (w[21] || !w[24]);
        bit saw = 0;
        bit got = 0;
        int waited = 0;
        int cyc = 0;
        @(negedge clk);
        instr = w; nzcv = f; base_val = b; offs_val = o; store_half = sh; start = 1'b1;
        #1;
        chk("R11 rf_base_idx", {28'h0, rf_base_idx}, {28'h0, w[19:16]});
        chk("R11 rf_offs_idx", {28'h0, rf_offs_idx}, {28'h0, w[3:0]});
        chk("R11 rf_src_idx", {28'h0, rf_src_idx}, {28'h0, w[15:12]});
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (done) begin got = 1; cyc = i; break; end
            if (mem_req) begin
                if (!saw) begin
                    chk("R3 mem_addr", mem_addr, acc);
                    chk("R6 mem_be", {28'h0, mem_be}, {28'h0, ebe});
                    chk("R7 mem_we", {31'h0, mem_we}, {31'h0, !ld});
                    if (!ld) chk("R7 mem_wdata", mem_wdata, {sh, sh});
                end
                saw = 1;
                if (waited >= lat) begin mem_ready = 1'b1; mem_rdata = rdat; end
                else waited++;
            end
            @(negedge clk);
            mem_ready = 1'b0;
            mem_rdata = $urandom;
        end
        chk("R8 done seen", {31'h0, got}, 32'h1);
        chk("R9 done timing", cyc, ex ? lat + 1 : 0);
        chk("R1 skipped", {31'h0, skipped}, {31'h0, !pass});
        chk("R2 unsupported", {31'h0, unsupported}, {31'h0, pass && !form});
        chk("R2 access made", {31'h0, saw}, {31'h0, ex});
        chk("R5 rd_we", {31'h0, rd_we}, {31'h0, ex && ld});
        if (ex && ld) begin
            chk("R5 rd_idx", {28'h0, rd_idx}, {28'h0, w[15:12]});
            chk("R5 rd_data", rd_data, m_ext(w[6:5], acc, rdat));
        end
        chk("R4 wb_we", {31'h0, wb_we}, {31'h0, ewb});
        if (ewb) begin
            chk("R4 wb_idx", {28'h0, wb_idx}, {28'h0, w[19:16]});
            chk("R4 wb_data", wb_data, nb);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R10 busy", {31'h0, busy}, 32'h0);
        chk("R10 mem_req", {31'h0, mem_req}, 32'h0);
        chk("R10 done", {31'h0, done}, 32'h0);
        chk("R10 rd_we", {31'h0, rd_we}, 32'h0);
        chk("R10 wb_we", {31'h0, wb_we}, 32'h0);
        rst_n = 1'b1;

        // R5 R6 unsigned half, pre-index up, upper half
        run_op(mk(4'hE, 1, 1, 0, 1, 4'd2, 4'd5, 2'b01, 4'd3), 4'h0, 32'h1000, 32'h22, 16'h0, 32'hBEEF1234, 0);
        // R3 R4 R6 signed byte post-index down, lane 3 negative
        run_op(mk(4'hE, 0, 0, 0, 1, 4'd7, 4'd1, 2'b10, 4'd9), 4'h0, 32'h2003, 32'h4, 16'h0, 32'h80112233, 1);
        // R6 byte lanes 0..2
        for (int k = 0; k < 3; k++)
            run_op(mk(4'hE, 1, 1, 1, 1, 4'd4, 4'd6, 2'b10, 4'd8), 4'h0, 32'h3000, k, 16'h0, 32'h7F80FF01, k);
        // R5 signed half, sign bit set, write-back, addr[0] ignored
        run_op(mk(4'hE, 1, 1, 1, 1, 4'd1, 4'd2, 2'b11, 4'd3), 4'h0, 32'h4001, 32'h0, 16'h0, 32'h12348001, 2);
        // R7 store high half with wait states
        run_op(mk(4'hE, 1, 0, 1, 0, 4'd3, 4'd4, 2'b01, 4'd5), 4'h0, 32'h5006, 32'h4, 16'hA55A, 32'h0, 3);
        run_op(mk(4'hE, 0, 1, 0, 0, 4'd3, 4'd4, 2'b01, 4'd5), 4'h0, 32'h5000, 32'h6, 16'h1234, 32'h0, 0);
        // R2 signed store, swap pattern, bad bit 22
        run_op(mk(4'hE, 1, 1, 0, 0, 4'd3, 4'd4, 2'b11, 4'd5), 4'h0, 32'h10, 32'h2, 16'h1, 32'h0, 0);
        run_op(mk(4'hE, 1, 1, 0, 1, 4'd3, 4'd4, 2'b00, 4'd5), 4'h0, 32'h10, 32'h2, 16'h1, 32'h0, 0);
        run_op(mk(4'hE, 1, 1, 0, 1, 4'd3, 4'd4, 2'b01, 4'd5) | 32'h0040_0000, 4'h0, 32'h10, 32'h2, 16'h1, 32'h0, 0);
        // R1 never code, NE with Z set, EQ with Z set, failing cond with bad form
        run_op(mk(4'hF, 1, 1, 1, 1, 4'd3, 4'd4, 2'b01, 4'd5), 4'hF, 32'h10, 32'h2, 16'h1, 32'h0, 0);
        run_op(mk(4'h1, 1, 1, 1, 1, 4'd3, 4'd4, 2'b01, 4'd5), 4'h4, 32'h10, 32'h2, 16'h1, 32'h0, 0);
        run_op(mk(4'h0, 1, 1, 1, 1, 4'd3, 4'd4, 2'b01, 4'd5), 4'h4, 32'h10, 32'h2, 16'h1, 32'hCAFEF00D, 0);
        run_op(mk(4'h0, 1, 1, 1, 1, 4'd3, 4'd4, 2'b00, 4'd5), 4'h0, 32'h10, 32'h2, 16'h1, 32'h0, 0);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w = $urandom;
            if ($urandom_range(7) != 0) begin
                w[27:25] = 3'b000; w[22] = 1'b0; w[11:8] = 4'h0; w[7] = 1'b1; w[4] = 1'b1;
            end
            if ($urandom_range(1) == 0) w[31:28] = 4'hE;
            run_op(w, 4'($urandom), $urandom, $urandom_range(255), 16'($urandom),
                   $urandom, $urandom_range(3));
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule